// File: doc/BRIEF.md
# Supervisor SPI Command Slave

This block is the serial command port of a power-supervisor chip. A host microcontroller drives it as an SPI master in mode 0. Each frame is 16 bits long and sits inside one active-low chip-select window. The block shifts the frame in and decodes it when chip select rises. It can then issue a one-cycle watchdog refresh strobe or a one-cycle configuration write strobe to the mode supervisor next to it. During the same frame it shifts a status byte back out.

Three signals enter the block from the supervisor: the current mode code, a byte of regulator flags, and a flag saying whether the low-power state keeps the main supply on. The block holds one flag of its own, the battery-fail flag. This flag is set by reset and cleared once the host has completed a regulator-flag read. All SPI pins are brought into the system clock domain through synchronisers.

Configuration writes are accepted only while the supervisor reports its initialisation mode. The block also raises a wake request when chip select toggles while the supervisor is in a low-power mode with the supply kept on.

Top module: `supv_spi_cmd_slave`

## Requirements
- R1: After reset the battery-fail flag is set, `wd_refresh`, `cfg_wr_stb` and `wake_req` are low, and the first regulator-flag read returns bit 1 as 1.
- R2: While `spi_cs_n` is high, `spi_miso` is high-impedance.
- R3: A complete frame equal to 16'h5A00 produces exactly one `wd_refresh` pulse, one clock wide, and no write strobe.
- R4: A frame whose upper byte is 8'hDD returns 8'h00 in response bits 15..8. Response bits 7..3 carry `sup_mode` (00000 init, 00001 flash, 00010 normal request, 00011 normal, 1xxxx low power) and bits 2..0 are zero.
- R5: A frame whose upper byte is 8'hDF returns `reg_flags` in response bits 7..0, with bit 1 replaced by the battery-fail flag. Response bits 15..8 are 8'h00.
- R6: A complete frame of 16'hDF00 or 16'hDF80 clears the battery-fail flag. Only reset sets it again.
- R7: A complete frame with bit 15 = 0, other than 16'h5A00, produces one `cfg_wr_stb` pulse when `sup_mode` is 00000. The pulse carries `cfg_wr_addr` = frame bits 14..8 and `cfg_wr_data` = frame bits 7..0. In any other mode the frame causes no strobe.
- R8: A frame of fewer or more than 16 SCLK rising edges causes no strobe and does not change the battery-fail flag.
- R9: While `sup_mode` bit 4 = 1 and `lp_supply_on` = 1, each edge of `spi_cs_n` produces one `wake_req` pulse. No pulse is produced otherwise.
- R10: MOSI is sampled on the rising edge of SCLK. MISO changes after each falling edge, most significant bit first, and bit 15 is driven before the first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, high-impedance when deselected |
| sup_mode | input | 5 | Current supervisor mode code |
| lp_supply_on | input | 1 | Low-power state keeps the main supply on |
| reg_flags | input | 8 | Regulator flag bits for the flag read |
| wd_refresh | output | 1 | One-cycle watchdog refresh strobe |
| cfg_wr_stb | output | 1 | One-cycle configuration write strobe |
| cfg_wr_addr | output | 7 | Write target, frame bits 14..8 |
| cfg_wr_data | output | 8 | Write data, frame bits 7..0 |
| wake_req | output | 1 | One-cycle wake request |

## Verification
The decoder is driven with regulator-flag reads, mode reads under several mode codes, the refresh code, and writes in both init and normal mode. Each read response therefore shows which input fed which bit. Each pair of strobe counts shows whether the mode gate and the exact refresh match hold. Flag reads are repeated back to back, and a flag byte with bit 1 set shows that the stored flag overrides that input bit. Frames of 8, 15 and 17 bits check that only an exact bit count acts. Chip-select toggles are made under three combinations of mode and supply-on, to separate the wake condition from its two inputs.

// File: rtl/supv_spi_pkg.sv
package supv_spi_pkg;
    localparam int          FRAME_BITS     = 16;
    localparam int          MODE_W         = 5;
    localparam logic [15:0] CMD_WD_REFRESH = 16'h5A00;
    localparam logic [7:0]  CMD_MODE_RD    = 8'hDD;
    localparam logic [7:0]  CMD_FLAG_RD    = 8'hDF;
    localparam logic [4:0]  MODE_INIT      = 5'b00000;
    localparam int          BATT_BIT       = 1;
    localparam logic [7:0]  HDR_BYTE       = 8'h00;
endpackage

// File: rtl/supv_spi_sync.sv
module supv_spi_sync #(
    parameter int               WIDTH  = 3,
    parameter int               STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_comb stage_d[g] = async_i;
            end else begin : g_next
                always_comb stage_d[g] = stage_q[g-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/supv_spi_shift.sv
module supv_spi_shift #(
    parameter int         FRAME_BITS = 16,
    parameter logic [7:0] HDR        = 8'h00
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sck_s,
    input  logic                  cs_s,
    input  logic                  mosi_s,
    input  logic [7:0]            resp_lo,
    output logic                  miso_bit,
    output logic [FRAME_BITS-1:0] frame_o,
    output logic                  done_o,
    output logic                  full_o,
    output logic                  cs_edge_o
);
    localparam int HALF  = FRAME_BITS / 2;
    localparam int CNT_W = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(HALF - 1);

    typedef struct packed {
        logic                  sck_prev;
        logic                  cs_prev;
        logic [CNT_W-1:0]      cnt;
        logic [FRAME_BITS-1:0] rx;
        logic [FRAME_BITS-1:0] tx;
        logic                  cmd_rdy;
        logic                  done;
        logic                  cs_edge;
    } shf_t;

    shf_t q, d;
    logic sck_rise, sck_fall, cs_fall, cs_rise;

    always_comb begin
        sck_rise = sck_s & ~q.sck_prev;
        sck_fall = ~sck_s & q.sck_prev;
        cs_fall  = ~cs_s & q.cs_prev;
        cs_rise  = cs_s & ~q.cs_prev;
        d          = q;
        d.sck_prev = sck_s;
        d.cs_prev  = cs_s;
        d.cmd_rdy  = 1'b0;
        d.done     = cs_rise;
        d.cs_edge  = cs_fall | cs_rise;
        if (cs_fall) begin
            d.cnt = '0;
            d.tx  = {HDR, {(FRAME_BITS-8){1'b0}}};
        end else if (!cs_s) begin
            if (sck_rise) begin
                d.rx = {q.rx[FRAME_BITS-2:0], mosi_s};
                if (q.cnt != CNT_MAX) d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_CMD) d.cmd_rdy = 1'b1;
            end
            if (sck_fall) d.tx = q.tx << 1;
            if (q.cmd_rdy) d.tx[FRAME_BITS-2 -: 8] = resp_lo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.cs_prev  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign miso_bit  = q.tx[FRAME_BITS-1];
    assign frame_o   = q.rx;
    assign done_o    = q.done;
    assign full_o    = (q.cnt == CNT_FULL);
    assign cs_edge_o = q.cs_edge;

    AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && $past(cs_s)) |=> $stable(q.rx)); // R10
    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_fall) |-> (q.cnt == '0)); // R8
endmodule

// File: rtl/supv_spi_decode.sv
module supv_spi_decode
    import supv_spi_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int MODE_WD = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               done_i,
    input  logic               full_i,
    input  logic               cs_edge_i,
    input  logic [MODE_WD-1:0] mode_i,
    input  logic               lp_on_i,
    input  logic [7:0]         flags_i,
    output logic [7:0]         resp_lo,
    output logic               wd_refresh,
    output logic               cfg_wr_stb,
    output logic [6:0]         cfg_wr_addr,
    output logic [7:0]         cfg_wr_data,
    output logic               wake_req
);
    typedef struct packed {
        logic       batt;
        logic       refr;
        logic       wr;
        logic [6:0] addr;
        logic [7:0] data;
        logic       wake;
    } dec_t;

    dec_t q, d;
    logic [7:0] cmd_byte;
    logic       is_lowpwr;

    always_comb begin
        cmd_byte  = frame_i[7:0];
        is_lowpwr = mode_i[MODE_WD-1];
        resp_lo   = 8'h00;
        if (cmd_byte == CMD_MODE_RD) begin
            resp_lo = {mode_i, 3'b000};
        end else if (cmd_byte == CMD_FLAG_RD) begin
            resp_lo           = flags_i;
            resp_lo[BATT_BIT] = q.batt;
        end

        d      = q;
        d.refr = 1'b0;
        d.wr   = 1'b0;
        d.wake = cs_edge_i & is_lowpwr & lp_on_i;
        if (done_i && full_i) begin
            if (frame_i == CMD_WD_REFRESH) begin
                d.refr = 1'b1;
            end else if (!frame_i[FRAME_W-1]) begin
                if (mode_i == MODE_INIT) begin
                    d.wr   = 1'b1;
                    d.addr = frame_i[FRAME_W-2 -: 7];
                    d.data = frame_i[7:0];
                end
            end else if (frame_i[FRAME_W-1 -: 8] == CMD_FLAG_RD && frame_i[6:0] == 7'd0) begin
                d.batt = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.batt <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign wd_refresh  = q.refr;
    assign cfg_wr_stb  = q.wr;
    assign cfg_wr_addr = q.addr;
    assign cfg_wr_data = q.data;
    assign wake_req    = q.wake;

    AST_REFRESH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wd_refresh |=> !wd_refresh); // R3
    AST_STROBE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_refresh || cfg_wr_stb) |-> $past(done_i && full_i)); // R8
    AST_WRITE_ONLY_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_stb |-> ($past(mode_i) == MODE_INIT)); // R7
    AST_BATT_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !q.batt |=> !q.batt); // R6
    AST_WAKE_LOWPOWER: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(mode_i[MODE_WD-1] && lp_on_i)); // R9
endmodule

// File: rtl/supv_spi_cmd_slave.sv
module supv_spi_cmd_slave
    import supv_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [MODE_W-1:0] sup_mode,
    input  logic              lp_supply_on,
    input  logic [7:0]        reg_flags,
    output logic              wd_refresh,
    output logic              cfg_wr_stb,
    output logic [6:0]        cfg_wr_addr,
    output logic [7:0]        cfg_wr_data,
    output logic              wake_req
);
    localparam int SYNC_STAGES = 2;

    logic [2:0]            pins_s;
    logic                  miso_bit;
    logic [FRAME_BITS-1:0] frame;
    logic                  done, full, cs_edge;
    logic [7:0]            resp_lo;

    supv_spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({spi_sck, spi_cs_n, spi_mosi}),
        .sync_o (pins_s)
    );

    supv_spi_shift #(.FRAME_BITS(FRAME_BITS), .HDR(HDR_BYTE)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_s    (pins_s[2]),
        .cs_s     (pins_s[1]),
        .mosi_s   (pins_s[0]),
        .resp_lo  (resp_lo),
        .miso_bit (miso_bit),
        .frame_o  (frame),
        .done_o   (done),
        .full_o   (full),
        .cs_edge_o(cs_edge)
    );

    supv_spi_decode #(.FRAME_W(FRAME_BITS), .MODE_WD(MODE_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_i    (frame),
        .done_i     (done),
        .full_i     (full),
        .cs_edge_i  (cs_edge),
        .mode_i     (sup_mode),
        .lp_on_i    (lp_supply_on),
        .flags_i    (reg_flags),
        .resp_lo    (resp_lo),
        .wd_refresh (wd_refresh),
        .cfg_wr_stb (cfg_wr_stb),
        .cfg_wr_addr(cfg_wr_addr),
        .cfg_wr_data(cfg_wr_data),
        .wake_req   (wake_req)
    );

    assign spi_miso = spi_cs_n ? 1'bz : miso_bit;

    AST_RESET_QUIET: assert property (@(posedge clk)
        $rose(rst_n) |-> !(wd_refresh || cfg_wr_stb || wake_req)); // R1
endmodule

// File: tb/sim_supv_spi_cmd_slave.sv
module sim_supv_spi_cmd_slave;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    wire  miso;
    logic [4:0] mode = 5'b00000;
    logic lp_on = 1'b0;
    logic [7:0] flags = 8'h00;
    logic wd_refresh, cfg_wr_stb, wake_req;
    logic [6:0] cfg_wr_addr;
    logic [7:0] cfg_wr_data;

    int checks = 0, bad = 0;
    int ref_cnt = 0, wr_cnt = 0, wake_cnt = 0;
    logic [6:0] last_addr = '0;
    logic [7:0] last_data = '0;

    always #5 clk = ~clk;

    supv_spi_cmd_slave u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .sup_mode(mode), .lp_supply_on(lp_on), .reg_flags(flags),
        .wd_refresh(wd_refresh), .cfg_wr_stb(cfg_wr_stb), .cfg_wr_addr(cfg_wr_addr),
        .cfg_wr_data(cfg_wr_data), .wake_req(wake_req)
    );

    always @(negedge clk) begin
        if (wd_refresh) ref_cnt++;
        if (wake_req) wake_cnt++;
        if (cfg_wr_stb) begin
            wr_cnt++;
            last_addr = cfg_wr_addr;
            last_data = cfg_wr_data;
        end
    end

    typedef struct packed {
        logic [15:0] cmd;
        logic [4:0]  mode;
        logic [7:0]  flags;
        logic [15:0] exp;
        logic        ref_e;
        logic        wr_e;
    } vec_t;

    localparam vec_t VEC [9] = '{
        '{16'hDF00, 5'b00000, 8'h00, 16'h0002, 1'b0, 1'b0}, // R1 R5 flag set at reset
        '{16'hDF80, 5'b00000, 8'h00, 16'h0000, 1'b0, 1'b0}, // R6 cleared by prior read
        '{16'hDF00, 5'b00000, 8'hA7, 16'h00A5, 1'b0, 1'b0}, // R5 bit 1 overridden
        '{16'hDD80, 5'b00011, 8'h00, 16'h0018, 1'b0, 1'b0}, // R4 normal
        '{16'hDD80, 5'b10110, 8'h00, 16'h00B0, 1'b0, 1'b0}, // R4 low power
        '{16'hDD80, 5'b00010, 8'h00, 16'h0010, 1'b0, 1'b0}, // R4 normal request
        '{16'h5A00, 5'b00011, 8'h00, 16'h0000, 1'b1, 1'b0}, // R3 refresh
        '{16'h1234, 5'b00000, 8'h00, 16'h0000, 1'b0, 1'b1}, // R7 write in init
        '{16'h1234, 5'b00011, 8'h00, 16'h0000, 1'b0, 1'b0}  // R7 write blocked
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
        rx = '0;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 16) ? tx[15-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            rx = {rx[14:0], miso};
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        #2ms;
        checks++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] rx;
        int r0, w0, k0;
        do_reset();
        chk("R1 strobes idle", {29'd0, wd_refresh, cfg_wr_stb, wake_req}, 32'd0);
        chk("R2 miso z", {31'd0, miso === 1'bz}, 32'd1);

        for (int v = 0; v < 9; v++) begin
            mode  = VEC[v].mode;
            flags = VEC[v].flags;
            r0 = ref_cnt;
            w0 = wr_cnt;
            xfer(VEC[v].cmd, 16, rx);
            chk($sformatf("R10 R4 R5 response vec%0d", v), {16'd0, rx}, {16'd0, VEC[v].exp});
            chk($sformatf("R3 refresh vec%0d", v), ref_cnt - r0, {31'd0, VEC[v].ref_e});
            chk($sformatf("R7 write vec%0d", v), wr_cnt - w0, {31'd0, VEC[v].wr_e});
            if (VEC[v].wr_e) chk("R7 addr/data", {17'd0, last_addr, last_data}, {17'd0, 7'h12, 8'h34});
        end
        chk("R2 miso z after frames", {31'd0, miso === 1'bz}, 32'd1);

        // R8 short and long refresh frames
        mode = 5'b00011;
        r0 = ref_cnt;
        xfer(16'h5A00, 15, rx);
        chk("R8 15-bit refresh ignored", ref_cnt - r0, 32'd0);
        xfer(16'h5A00, 17, rx);
        chk("R8 17-bit refresh ignored", ref_cnt - r0, 32'd0);
        mode = 5'b00000;
        w0 = wr_cnt;
        xfer(16'h1234, 8, rx);
        chk("R8 8-bit write ignored", wr_cnt - w0, 32'd0);

        // R8 partial flag read must keep flag; R1 reset sets it again
        do_reset();
        xfer(16'hDF00, 8, rx);
        xfer(16'hDF00, 16, rx);
        chk("R8 R1 flag kept after short read", {16'd0, rx}, 32'h0002);
        xfer(16'hDF00, 16, rx);
        chk("R6 flag cleared", {16'd0, rx}, 32'h0000);

        // R9 wake request
        mode = 5'b10000;
        lp_on = 1'b1;
        k0 = wake_cnt;
        xfer(16'hDD80, 16, rx);
        chk("R9 wake on both cs edges", wake_cnt - k0, 32'd2);
        chk("R4 low-power code", {16'd0, rx}, 32'h0080);
        lp_on = 1'b0;
        k0 = wake_cnt;
        xfer(16'hDD80, 16, rx);
        chk("R9 no wake supply off", wake_cnt - k0, 32'd0);
        mode = 5'b00011;
        lp_on = 1'b1;
        xfer(16'hDD80, 16, rx);
        chk("R9 no wake in normal", wake_cnt - k0, 32'd0);

        finish_run();
    end
endmodule